// File: doc/BRIEF.md
# Globally Ordered Snoop Request Sequencer

This block sits beside one router of a mesh network-on-chip. It hands broadcast coherence requests to the local core in a single global order that every node reproduces. Snooping coherence therefore keeps working without a shared bus. A separate, fast announcement network tells the block at fixed boundaries which cores issued a request during the interval that just ended. The request packets themselves travel over the main mesh, can arrive in any order, and wait in a per-source holding slot until their turn.

Every interval gets its own priority ranking, which is a rotation of the core indices. The rotation moves one place per interval, so over time no core is favoured. The block works through one interval completely before it starts the next. Within an interval it releases requests only in ranking order. A packet that arrives before its turn stays parked until every higher-ranked announced packet of the same interval has gone out.

Both packet interfaces are valid/ready. On the input side, `req_ready` drops while the slot of the addressed source is still occupied. The mesh must then hold the packet, with its source and payload unchanged, until ready returns. On the output side, once `out_valid` is raised it stays raised with constant source and payload until `out_ready` completes the handshake. Back-pressure on the output stalls the whole sequence.

Top module: `snoop_order_seq`

## Requirements
- R1: After reset `out_valid` is 0, `req_ready` is 1 for every valid source, and the local interval index is 0.
- R2: `ann_strobe` is high for exactly one cycle every `INTERVAL_CYC` cycles. The first strobe comes in the cycle `INTERVAL_CYC-1` clock edges after reset is released. `ann_vec` is sampled in each strobe cycle, with bit i set meaning core i issued one request in the interval that closed.
- R3: The interval recorded at the j-th strobe after reset (j counted from 0) ranks cores starting at core (j mod N_SRC), followed by increasing index with wrap-around to 0.
- R4: The announced requests of an interval are released strictly in that ranking. A lower-ranked packet that arrives early is held, and `out_valid` stays 0 until the higher-ranked packets have arrived and been released.
- R5: Intervals are serviced in strobe order. No request of interval j+1 is released before every announced request of interval j. Up to `NOTE_DEPTH` recorded intervals may be pending.
- R6: An interval whose vector is all zero retires in one cycle without producing any output, and it still advances the rotation by one.
- R7: `req_ready` is 0 exactly when the slot of `req_src` is occupied. A packet is stored when `req_valid` and `req_ready` are both high, and each source holds at most one packet.
- R8: At most one request is released per cycle. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_src` and `out_payload` hold. The source's slot is freed on the handshake.
- R9: `out_payload` equals the payload that was stored for `out_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ann_vec | input | N_SRC | Per-core issue vector, sampled while `ann_strobe` is high |
| ann_strobe | output | 1 | Interval boundary; vector sampled this cycle |
| req_valid | input | 1 | Incoming request packet valid |
| req_ready | output | 1 | Slot for `req_src` is free |
| req_src | input | SRC_W | Source core of the incoming packet |
| req_payload | input | PAY_W | Payload of the incoming packet |
| out_valid | output | 1 | Released request valid |
| out_ready | input | 1 | Local core accepts the released request |
| out_src | output | SRC_W | Source core of the released request |
| out_payload | output | PAY_W | Payload of the released request |

## Verification
The bench walks through every non-empty announcement vector of a five-core build. It delivers packets either in reverse ranking or in ranking order, and it stalls the output on some runs. A design that rotated from the wrong base, or failed to rotate across the idle intervals in between, would release sources in the wrong order. A design that did not hold early arrivals would show `out_valid` before the top-ranked packet has arrived. A two-interval case delivers the later interval's packets first, which catches a sequencer that lets intervals overlap. A stalled-output case checks that the output holds steady and that a second packet to an occupied slot is refused.

// File: rtl/gos_pkg.sv
package gos_pkg;
  // Add b to a modulo n, for 0 <= a,b < n.
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/gos_interval_timer.sv
module gos_interval_timer #(
  parameter int INTERVAL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int CW = $clog2(INTERVAL_CYC + 1);
  logic [CW-1:0] cnt;

  assign strobe = (cnt == CW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  generate
    if (INTERVAL_CYC > 1) begin : g_gap
      AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R2
    end
  endgenerate
endmodule

// File: rtl/gos_note_fifo.sv
module gos_note_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop)
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
endmodule

// File: rtl/gos_rot_picker.sv
module gos_rot_picker #(
  parameter int N     = 36,
  parameter int SRC_W = 6
) (
  input  logic [N-1:0]     mask,
  input  logic [SRC_W-1:0] base,
  output logic             any,
  output logic [SRC_W-1:0] idx
);
  import gos_pkg::*;

  // Scan from lowest rank upward so the highest-ranked hit is written last.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int j;
      j = wrap_add(int'(base), i, N);
      if (mask[j]) begin
        any = 1'b1;
        idx = SRC_W'(j);
      end
    end
  end
endmodule

// File: rtl/gos_src_slots.sv
module gos_src_slots #(
  parameter int N     = 36,
  parameter int SRC_W = 6,
  parameter int PAY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_src,
  input  logic [PAY_W-1:0] wr_data,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_src,
  input  logic [SRC_W-1:0] rd_src,
  output logic [PAY_W-1:0] rd_data,
  output logic [N-1:0]     occ
);
  logic [PAY_W-1:0] pay [N];

  assign rd_data = pay[rd_src];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      if (clr_en) occ[clr_src] <= 1'b0;
      if (wr_en) begin
        occ[wr_src] <= 1'b1;
        pay[wr_src] <= wr_data;
      end
    end
  end

  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !occ[wr_src]); // R7
endmodule

// File: rtl/snoop_order_seq.sv
module snoop_order_seq #(
  parameter int N_SRC        = 36,
  parameter int PAY_W        = 32,
  parameter int INTERVAL_CYC = 16,
  parameter int NOTE_DEPTH   = 4,
  localparam int SRC_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ann_vec,
  output logic             ann_strobe,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SRC_W-1:0] req_src,
  input  logic [PAY_W-1:0] req_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SRC_W-1:0] out_src,
  output logic [PAY_W-1:0] out_payload
);
  import gos_pkg::*;

  logic [N_SRC-1:0] head_vec, done, pend, occ;
  logic             fifo_empty, any_pend, retire, out_fire, in_fire;
  logic [SRC_W-1:0] rot_base, sel;

  gos_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .strobe(ann_strobe));

  gos_note_fifo #(.W(N_SRC), .DEPTH(NOTE_DEPTH)) u_notes (
    .clk(clk), .rst_n(rst_n), .push(ann_strobe), .push_data(ann_vec),
    .pop(retire), .head(head_vec), .empty(fifo_empty));

  assign pend = fifo_empty ? '0 : (head_vec & ~done);

  gos_rot_picker #(.N(N_SRC), .SRC_W(SRC_W)) u_pick (
    .mask(pend), .base(rot_base), .any(any_pend), .idx(sel));

  assign retire    = !fifo_empty && !any_pend;
  assign out_valid = any_pend && occ[sel];
  assign out_src   = sel;
  assign out_fire  = out_valid && out_ready;
  assign req_ready = (int'(req_src) < N_SRC) && !occ[req_src];
  assign in_fire   = req_valid && req_ready;

  gos_src_slots #(.N(N_SRC), .SRC_W(SRC_W), .PAY_W(PAY_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_fire), .wr_src(req_src), .wr_data(req_payload),
    .clr_en(out_fire), .clr_src(sel),
    .rd_src(sel), .rd_data(out_payload), .occ(occ));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= '0;
      rot_base <= '0;
    end else if (retire) begin
      done     <= '0;
      rot_base <= SRC_W'(wrap_add(int'(rot_base), 1, N_SRC));
    end else if (out_fire) begin
      done[sel] <= 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_payload)); // R8
  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> !(out_valid && out_src == $past(out_src))); // R8
endmodule

// File: tb/snoop_order_seq_test.sv
`timescale 1ns/1ps
module snoop_order_seq_test;
  localparam int N  = 5;
  localparam int PW = 8;
  localparam int IV = 6;
  localparam int SW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic [N-1:0] ann_vec = '0;
  logic ann_strobe, req_valid = 0, req_ready, out_valid, out_ready = 0;
  logic [SW-1:0] req_src = '0, out_src;
  logic [PW-1:0] req_payload = '0, out_payload;

  int checks = 0, fails = 0, strobe_cnt = 0, stall_mode = 0, cyc = 0;
  int exp_src [512];
  int exp_pay [512];
  int eh = 0, et = 0;

  always #2 clk = ~clk;

  snoop_order_seq #(.N_SRC(N), .PAY_W(PW), .INTERVAL_CYC(IV), .NOTE_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .ann_vec(ann_vec), .ann_strobe(ann_strobe),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_payload(req_payload), .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_payload(out_payload));

  function automatic int pay_of(int k, int s);
    return ((k * 7 + s * 13) ^ 8'h5A) & 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && ann_strobe) strobe_cnt <= strobe_cnt + 1;
  end

  always @(posedge clk) begin
    #1;
    case (stall_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // Order monitor: R3 R4 R5 R6 R9
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (eh == et) begin
        chk(0, "R4", "unexpected release src", int'(out_src), -1);
      end else begin
        chk(int'(out_src) == exp_src[eh], "R3 R4 R6", "release order src",
            int'(out_src), exp_src[eh]);
        chk(int'(out_payload) == exp_pay[eh], "R9", "payload",
            int'(out_payload), exp_pay[eh]);
        eh++;
      end
    end
  end

  task automatic announce(input logic [N-1:0] v, output int k);
    @(negedge clk);
    while (!ann_strobe) @(negedge clk);
    ann_vec = v;
    k = strobe_cnt;
    for (int i = 0; i < N; i++) begin
      int s;
      s = (k + i) % N;
      if (v[s]) begin
        exp_src[et] = s;
        exp_pay[et] = pay_of(k, s);
        et++;
      end
    end
    @(negedge clk);
    ann_vec = '0;
  endtask

  task automatic send(input int s, input int k);
    req_valid = 1;
    req_src = SW'(s);
    req_payload = PW'(pay_of(k, s));
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // ranked list of announced sources for interval k
  task automatic rank(input logic [N-1:0] v, input int k,
                      output int lst [N], output int n);
    n = 0;
    for (int i = 0; i < N; i++) begin
      int s;
      s = (k + i) % N;
      if (v[s]) begin lst[n] = s; n++; end
    end
  endtask

  task automatic drain();
    while (eh != et) @(negedge clk);
  endtask

  task automatic do_interval(input logic [N-1:0] v, input int mode);
    int k, n;
    int lst [N];
    announce(v, k);
    rank(v, k, lst, n);
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = (mode == 0) ? (n - 1 - i) : i;
      if (mode == 0 && i == n - 1 && n > 1)
        chk(out_valid == 0, "R4", "held before top-ranked arrives", int'(out_valid), 0);
      send(lst[idx], k);
    end
    drain();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, k1, k2, ka;
    int l1 [N];
    int l2 [N];
    int n1, n2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(req_ready == 1, "R1", "req_ready after reset", int'(req_ready), 1);
    // R2: strobe position and spacing
    n = 0;
    while (!ann_strobe) begin @(negedge clk); n++; end
    chk(n == IV - 1, "R2", "first strobe distance", n, IV - 1);
    n = 0;
    @(negedge clk); n++;
    while (!ann_strobe) begin @(negedge clk); n++; end
    chk(n == IV, "R2", "strobe period", n, IV);

    // Sweep every non-empty vector (R3 R4 R6 R8 R9)
    for (int v = 1; v < (1 << N); v++) begin
      stall_mode = (v % 3 == 0) ? 1 : 0;
      do_interval(N'(v), v % 2);
    end
    stall_mode = 0;

    // R5: two intervals pending, later one's packets delivered first
    announce(5'b00101, k1);
    announce(5'b11010, k2);
    rank(5'b00101, k1, l1, n1);
    rank(5'b11010, k2, l2, n2);
    for (int i = 0; i < n2; i++) send(l2[i], k2);
    chk(out_valid == 0, "R5", "later interval blocked", int'(out_valid), 0);
    for (int i = n1 - 1; i >= 0; i--) send(l1[i], k1);
    drain();

    // R7 R8: output stall and slot back-pressure
    stall_mode = 2;
    @(negedge clk); @(negedge clk);
    announce(5'b00100, ka);
    send(2, ka);
    @(negedge clk);
    chk(out_valid == 1, "R8", "valid while stalled", int'(out_valid), 1);
    chk(int'(out_src) == 2, "R8", "src while stalled", int'(out_src), 2);
    req_src = SW'(2);
    #1;
    chk(req_ready == 0, "R7", "occupied slot refuses", int'(req_ready), 0);
    req_src = SW'(3);
    #1;
    chk(req_ready == 1, "R7", "free slot accepts", int'(req_ready), 1);
    repeat (3) @(negedge clk);
    chk(out_valid == 1 && int'(out_src) == 2, "R8", "held over stall",
        int'(out_src), 2);
    chk(int'(out_payload) == pay_of(ka, 2), "R8", "payload held",
        int'(out_payload), pay_of(ka, 2));
    stall_mode = 0;
    drain();
    @(negedge clk);
    req_src = SW'(2);
    #1;
    chk(req_ready == 1, "R8", "slot freed on handshake", int'(req_ready), 1);
    chk(eh == et, "R4", "all expected released", eh, et);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule